// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block produces a periodic tick interrupt from a slow base-rate strobe. The strobe is nominally 32.768 kHz and arrives as a one-cycle pulse in the system clock domain. A free-running 15-bit prescaler divides the strobe by a power of two, picked by a 4-bit select field in the control register. The divided strobe steps a down-counter. When the down-counter expires it reloads itself from a programmable period register, sets a pending flag and drives the interrupt line.

Software reaches the block through a small word-addressed register port. The port has one write channel, and a read channel that returns data on the cycle after the address is presented. The control word holds three fields. Bit 0 is the master enable. Bits 7:4 are the prescaler select. Bit 8 is the tick enable. The timer starts only on a rising edge of the tick enable, written while the master enable is set and the period register is nonzero. The live count can be read at any time. The pending flag is cleared by writing 1 to bit 0 of its register.

Register addresses: 0 is the control word (bits 8:0 read back), 1 is the period, 2 is the live count (read-only), 3 is the pending flag (bit 0).

Top module: `prescaled_tick_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0, the timer is stopped and irq is low.
- R2: With select value s in control bits 7:4, the down-counter steps once on every base strobe for which the prescaler's low s bits are all ones, i.e. once per 2^s strobes, and holds otherwise.
- R3: A write to address 1 is stored only when the whole written word is greater than 2; a write of 0, 1 or 2 leaves the stored period unchanged.
- R4: A control write with bit 0 set, bit 8 set, bit 8 previously clear and a nonzero period loads the period into the live count and starts the timer.
- R5: A control write with bit 8 rising does not start the timer when bit 0 of the same write is clear or the period is 0.
- R6: A control write that clears bit 8 while it was set, or clears bit 0 while it was set, stops the timer; the live count then holds its value.
- R7: When the running counter steps while it holds 1, it reloads the period, the pending flag (address 3 bit 0) is set, irq rises on the next cycle, and counting continues.
- R8: Writing 1 to address 3 bit 0 clears the pending flag and irq; writing 0 there has no effect; an expiry in the same cycle wins over the clear.
- R9: Reading address 2 returns the live down-counter value one cycle after the read address is presented.
- R10: A change to the prescaler select while running does not reload the live count; the new division applies from the next prescaler edge.
- R11: A period write while running does not disturb the live count; the new period is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle base-rate strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Registered read data, one cycle after rd_addr |
| irq | output | 1 | Tick interrupt, mirrors the pending flag |

## Verification
The bench walks through the conditions around starting the timer: a rising tick enable with the master enable clear, with a zero period, and with a valid period. A design that skipped the edge or the period test would start counting and show a live value where 0 is expected. It writes periods of 0, 1 and 2 between valid ones, which would expose a design that accepts too small a period, and it rewrites the period and the select mid-run, where a design that reloads eagerly would jump the live count. It also hammers the pending clear around expiries and steps the select up to the widest division, where an off-by-one in the prescaler mask shows up as a wrong step spacing.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int ADDR_W       = 2;
  localparam int CTRL_W       = 9;
  localparam int SEL_W        = 4;
  localparam int CTRL_ON_BIT  = 0;
  localparam int CTRL_SEL_LSB = 4;
  localparam int CTRL_TIC_BIT = 8;
  localparam int MIN_PERIOD   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_PERIOD = 2'd1,
    A_LIVE   = 2'd2,
    A_PEND   = 2'd3
  } tt_addr_e;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler import tt_pkg::*; #(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             stb
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  // mask has the low 'sel' bits set; a carry out of them is the selected edge
  for (genvar g = 0; g < PRE_W; g++) begin : gen_mask
    assign mask[g] = (int'(sel) > g);
  end

  always_ff @(posedge clk) begin
    if (rst)            div_q <= '0;
    else if (base_tick) div_q <= div_q + 1'b1;
  end

  assign stb = base_tick && ((div_q & mask) == mask);
endmodule

// File: rtl/tt_downcount.sv
module tt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             stb,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] live,
  output logic             expire
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live  <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      live  <= period;
      run_q <= 1'b1;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q && stb) begin
      live <= (live == CNT_W'(1)) ? period : live - 1'b1;
    end
  end

  assign expire = run_q && stb && !start && !stop && (live == CNT_W'(1));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> (live == $past(period)));
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> (live == $past(period)));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && stb && !start && !stop && live > CNT_W'(1)) |=> (live == $past(live) - 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!stb && !start) |=> $stable(live));
  assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> (!run_q && $stable(live)));
endmodule

// File: rtl/tt_regs.sv
module tt_regs import tt_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  live,
  input  logic              expire,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  period,
  output logic              start,
  output logic              stop,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic              pend_q;
  logic              wr_ctrl, wr_period, wr_pend;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_period = wr_en && (wr_addr == A_PERIOD);
  assign wr_pend   = wr_en && (wr_addr == A_PEND);

  assign start = wr_ctrl && wr_data[CTRL_ON_BIT] && wr_data[CTRL_TIC_BIT]
                 && !ctrl_q[CTRL_TIC_BIT] && (period_q != '0);
  assign stop  = wr_ctrl && ((ctrl_q[CTRL_TIC_BIT] && !wr_data[CTRL_TIC_BIT]) ||
                             (ctrl_q[CTRL_ON_BIT]  && !wr_data[CTRL_ON_BIT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      pend_q   <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_period && (wr_data > DATA_W'(MIN_PERIOD))) period_q <= wr_data[CNT_W-1:0];
      if (expire)                     pend_q <= 1'b1;
      else if (wr_pend && wr_data[0]) pend_q <= 1'b0;
      case (rd_addr)
        A_CTRL:   rd_data <= DATA_W'(ctrl_q);
        A_PERIOD: rd_data <= DATA_W'(period_q);
        A_LIVE:   rd_data <= DATA_W'(live);
        default:  rd_data <= DATA_W'(pend_q);
      endcase
    end
  end

  assign sel    = ctrl_q[CTRL_SEL_LSB +: SEL_W];
  assign period = period_q;
  assign irq    = pend_q;

  assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_period && wr_data <= DATA_W'(MIN_PERIOD)) |=> $stable(period_q));
  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && wr_data[0] && !expire) |=> !irq);
  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && !wr_data[0] && pend_q) |=> irq);
endmodule

// File: rtl/prescaled_tick_timer.sv
module prescaled_tick_timer import tt_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] period, live;
  logic             start, stop, stb, expire;

  tt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .base_tick(base_tick), .sel(sel), .stb(stb)
  );

  tt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .stb(stb),
    .period(period), .live(live), .expire(expire)
  );

  tt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .live(live), .expire(expire), .sel(sel), .period(period),
    .start(start), .stop(stop), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: tb/prescaled_tick_timer_test.sv
module prescaled_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  prescaled_tick_timer uut (
    .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0, bmode = 0;
  string phase = "R1";

  // behavioural reference model
  int unsigned m_pre, m_ctrl, m_per, m_live, m_rd;
  bit m_run, m_pend;
  always @(posedge clk) begin
    int unsigned s, msk, nxt_rd;
    bit st, stp, go, exp_now;
    if (rst) begin
      m_pre = 0; m_ctrl = 0; m_per = 0; m_live = 0; m_run = 0; m_pend = 0; m_rd = 0;
    end else begin
      s   = (m_ctrl >> 4) & 15;
      msk = (1 << s) - 1;
      st  = base_tick && ((m_pre & msk) == msk);
      case (rd_addr)
        2'd0: nxt_rd = m_ctrl;
        2'd1: nxt_rd = m_per;
        2'd2: nxt_rd = m_live;
        default: nxt_rd = m_pend;
      endcase
      go  = wr_en && wr_addr == 0 && wr_data[0] && wr_data[8] && !m_ctrl[8] && m_per != 0;
      stp = wr_en && wr_addr == 0 && ((m_ctrl[8] && !wr_data[8]) || (m_ctrl[0] && !wr_data[0]));
      exp_now = 0;
      if (go) begin m_live = m_per; m_run = 1; end
      else if (stp) m_run = 0;
      else if (m_run && st) begin
        if (m_live == 1) begin m_live = m_per; exp_now = 1; end
        else m_live = m_live - 1;
      end
      if (exp_now) m_pend = 1;
      else if (wr_en && wr_addr == 3 && wr_data[0]) m_pend = 0;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data & 32'h1FF;
      if (wr_en && wr_addr == 1 && wr_data > 2) m_per = wr_data & 32'hFFFF;
      if (base_tick) m_pre = (m_pre + 1) % 32768;
      m_rd = nxt_rd;
    end
  end

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (!rst) begin
      expect32({phase, " rd_data"}, rd_data, m_rd);
      expect32({phase, " irq"}, {31'd0, irq}, {31'd0, m_pend});
    end
    base_tick = (bmode == 0) ? 1'b1 : (bmode == 1) ? (cyc % 3 == 0) : 1'b0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_now(logic [1:0] a, string tag, logic [31:0] exp);
    rd_addr = a;
    step();
    expect32(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bmode = 0;
    steps(4);
    rst = 1'b0;
    phase = "R1";
    rd_now(2'd0, "R1 ctrl", 0);
    rd_now(2'd1, "R1 period", 0);
    rd_now(2'd2, "R1 live", 0);
    rd_now(2'd3, "R1 pend", 0);
    // R5: zero period blocks start
    phase = "R5";
    wr(2'd0, 32'h101);
    rd_addr = 2'd2; steps(6);
    expect32("R5 zero period live", rd_data, 0);
    wr(2'd0, 32'h0);
    // R3: period acceptance
    phase = "R3";
    wr(2'd1, 2); rd_now(2'd1, "R3 reject 2", 0);
    wr(2'd1, 1); wr(2'd1, 5); rd_now(2'd1, "R3 accept 5", 5);
    wr(2'd1, 2); wr(2'd1, 0); rd_now(2'd1, "R3 keep 5", 5);
    // R5: master clear blocks start
    phase = "R5";
    wr(2'd0, 32'h100);
    rd_addr = 2'd2; steps(6);
    expect32("R5 master off live", rd_data, 0);
    wr(2'd0, 32'h0);
    // R4, R7, R9: run at select 0
    phase = "R4";
    wr(2'd0, 32'h101);
    rd_now(2'd2, "R4 load", 5);
    phase = "R9"; steps(4);
    phase = "R7"; steps(20);
    // R8: pending clear behaviour
    phase = "R8";
    rd_addr = 2'd3;
    wr(2'd3, 32'h0);
    for (int i = 0; i < 12; i++) wr(2'd3, 32'h1);
    steps(3);
    // R10: select change mid-run, sparse base strobes
    phase = "R10"; bmode = 1; rd_addr = 2'd2;
    wr(2'd0, 32'h121);
    steps(80);
    // R11: period change mid-run
    phase = "R11";
    wr(2'd1, 7);
    steps(100);
    // R6: stop by tick clear, restart, stop by master clear
    phase = "R6";
    wr(2'd0, 32'h021);
    rd_addr = 2'd2; steps(30);
    wr(2'd0, 32'h121);
    steps(20);
    wr(2'd0, 32'h120);
    steps(30);
    wr(2'd0, 32'h0);
    // R2: widest division and mid-range division
    phase = "R2"; bmode = 0;
    wr(2'd1, 3);
    wr(2'd0, 32'h131);
    steps(200);
    wr(2'd0, 32'h031);
    wr(2'd0, 32'h1F1);
    steps(40000);
    phase = "R1";
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule